// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the status side of a serial port's modem interface. Four incoming handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect) are brought into the clock domain through a two-stage synchronizer. The block compares each synchronized value with the value it sampled on the previous cycle, and records every change in a sticky delta bit. The host reads one 8-bit status byte. Reading it clears the delta bits, and a single `delta_any` output tells the interrupt logic that some change is waiting to be seen.

For the ring line, only a falling edge is recorded: the line going from asserted to deasserted. When the loopback bit of the modem control value is set, the block ignores the external lines. It takes the four modem control outputs in their place, with no synchronizer, so that software can test the status path without a cable. The control register itself lives outside this block and is supplied as an input. Its reset value holds only the OUT2 bit.

Top module: `modem_status_reg`

## Requirements
- R1: The status byte carries the current line levels in its upper nibble: carrier detect at bit 7, ring at bit 6, data-set-ready at bit 5, clear-to-send at bit 4. An external pin change appears there on the third rising edge after it is driven, and not earlier.
- R2: A change in either direction on clear-to-send, data-set-ready or carrier detect sets the matching delta bit: bit 0, bit 1 and bit 3 in that order. The bit is set on the same edge as the level update.
- R3: Ring delta bit 2 is set only when ring goes from 1 to 0. A 0-to-1 ring change leaves bit 2 clear.
- R4: A cycle with `rd_stb` high clears all four delta bits at the next rising edge.
- R5: A line change that reaches the delta logic on the same edge as a clearing read leaves its delta bit set. Deltas that were already pending are still cleared.
- R6: Delta bits stay set across any number of cycles until a read.
- R7: The control input uses these bit positions: DTR = bit 0, RTS = bit 1, OUT1 = bit 2, OUT2 = bit 3, LOOP = bit 4. With LOOP set, OUT2 drives carrier detect, OUT1 drives ring, RTS drives clear-to-send and DTR drives data-set-ready, one edge after the control value changes. The external pins have no effect while LOOP is set. Level changes caused by entering or leaving loopback set deltas like any other change.
- R8: After reset the status byte reads 0xB0 (carrier detect, data-set-ready and clear-to-send set, no deltas) and `delta_any` is 0.
- R9: `delta_any` is 1 exactly when at least one of status bits 3..0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin | input | 1 | Clear-to-send line, asynchronous, active high |
| dsr_pin | input | 1 | Data-set-ready line, asynchronous, active high |
| ri_pin | input | 1 | Ring indicator line, asynchronous, active high |
| dcd_pin | input | 1 | Carrier detect line, asynchronous, active high |
| ctl_bits | input | 5 | Modem control value: LOOP, OUT2, OUT1, RTS, DTR |
| rd_stb | input | 1 | One-cycle strobe marking a status read |
| status_q | output | 8 | Status byte: levels in bits 7..4, deltas in bits 3..0 |
| delta_any | output | 1 | At least one delta bit pending |

## Verification
Two actions can meet on one edge: a host read that clears the deltas, and a line change that sets one. To force this, the bench first leaves a data-set-ready delta pending. It then drops clear-to-send and raises `rd_stb` in the cycle just before the synchronized change reaches the delta register. The status byte after that edge must show the old delta cleared and the new clear-to-send delta set (0x81). The same clear-then-set race also happens when loopback is entered or left during a read. The bench covers it by checking the deltas produced by each loopback transition.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NLINES = 4;
  // line index inside the level/delta nibbles
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  // modem control bit positions
  localparam int CTL_W    = 5;
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;
  // carrier, data-set-ready and clear-to-send high after reset
  localparam logic [NLINES-1:0] LINES_RST = 4'b1011;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/msr_line_mux.sv
module msr_line_mux
  import msr_pkg::*;
(
  input  logic [NLINES-1:0] ext_lines,
  input  logic [CTL_W-1:0]  ctl,
  output logic [NLINES-1:0] lines
);
  always_comb begin
    if (ctl[CTL_LOOP]) begin
      lines[IDX_DCD] = ctl[CTL_OUT2];
      lines[IDX_RI]  = ctl[CTL_OUT1];
      lines[IDX_DSR] = ctl[CTL_DTR];
      lines[IDX_CTS] = ctl[CTL_RTS];
    end else begin
      lines = ext_lines;
    end
  end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] lines,
  input  logic              rd_stb,
  output logic [NLINES-1:0] lvl,
  output logic [NLINES-1:0] dlt
);
  logic [NLINES-1:0] hit;

  for (genvar i = 0; i < NLINES; i++) begin : g_bit
    if (i == IDX_RI) begin : g_trail
      assign hit[i] = lvl[i] & ~lines[i];
    end else begin : g_any
      assign hit[i] = lvl[i] ^ lines[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= LINES_RST;
      dlt <= '0;
    end else begin
      lvl <= lines;
      dlt <= (rd_stb ? '0 : dlt) | hit;
    end
  end

  // R2
  cts_delta_chk: assert property (@(posedge clk) disable iff (rst)
    (lines[IDX_CTS] != lvl[IDX_CTS]) |=> dlt[IDX_CTS]);
  // R3
  ri_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!lvl[IDX_RI] && lines[IDX_RI] && !dlt[IDX_RI]) |=> !dlt[IDX_RI]);
  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && lines == lvl) |=> dlt == '0);
  // R5
  race_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && lvl[IDX_DCD] != lines[IDX_DCD]) |=> dlt[IDX_DCD]);
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb) |=> ((dlt & $past(dlt)) == $past(dlt)));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cts_pin,
  input  logic             dsr_pin,
  input  logic             ri_pin,
  input  logic             dcd_pin,
  input  logic [CTL_W-1:0] ctl_bits,
  input  logic             rd_stb,
  output logic [7:0]       status_q,
  output logic             delta_any
);
  logic [NLINES-1:0] raw_lines, sync_lines, sel_lines, lvl, dlt;

  always_comb begin
    raw_lines[IDX_CTS] = cts_pin;
    raw_lines[IDX_DSR] = dsr_pin;
    raw_lines[IDX_RI]  = ri_pin;
    raw_lines[IDX_DCD] = dcd_pin;
  end

  msr_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINES_RST)) u_sync (
    .clk(clk), .rst(rst), .din(raw_lines), .dout(sync_lines));

  msr_line_mux u_mux (.ext_lines(sync_lines), .ctl(ctl_bits), .lines(sel_lines));

  msr_delta u_delta (
    .clk(clk), .rst(rst), .lines(sel_lines), .rd_stb(rd_stb),
    .lvl(lvl), .dlt(dlt));

  assign status_q  = {lvl, dlt};
  assign delta_any = |dlt;

  // R7
  loop_map_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_bits[CTL_LOOP] |=> status_q[7:4] ==
      {$past(ctl_bits[CTL_OUT2]), $past(ctl_bits[CTL_OUT1]),
       $past(ctl_bits[CTL_DTR]), $past(ctl_bits[CTL_RTS])});
  // R8
  reset_val_chk: assert property (@(posedge clk)
    rst |=> (status_q == 8'hB0 && !delta_any));
endmodule

// File: tb/modem_status_reg_test.sv
module modem_status_reg_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_pin = 1'b1, dsr_pin = 1'b1, ri_pin = 1'b0, dcd_pin = 1'b1;
  logic [4:0] ctl_bits = 5'b01000;
  logic rd_stb = 1'b0;
  logic [7:0] status_q;
  logic delta_any;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_reg uut (
    .clk(clk), .rst(rst), .cts_pin(cts_pin), .dsr_pin(dsr_pin),
    .ri_pin(ri_pin), .dcd_pin(dcd_pin), .ctl_bits(ctl_bits),
    .rd_stb(rd_stb), .status_q(status_q), .delta_any(delta_any));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 status", status_q, 8'hB0);
    check("R8 delta_any", {7'd0, delta_any}, 8'h00);
  endtask

  task automatic t_cts();
    cts_pin = 1'b0;
    edges(2);
    check("R1 latency", status_q, 8'hB0);
    edges(1);
    check("R2 cts fall", status_q, 8'hA1);
    check("R9 any set", {7'd0, delta_any}, 8'h01);
    edges(5);
    check("R6 sticky", status_q, 8'hA1);
    do_read();
    check("R4 clear", status_q, 8'hA0);
    check("R9 any clear", {7'd0, delta_any}, 8'h00);
    cts_pin = 1'b1;
    edges(3);
    check("R2 cts rise", status_q, 8'hB1);
    do_read();
    check("R4 clear2", status_q, 8'hB0);
  endtask

  task automatic t_ring();
    ri_pin = 1'b1;
    edges(3);
    check("R3 ring rise", status_q, 8'hF0);
    ri_pin = 1'b0;
    edges(3);
    check("R3 ring fall", status_q, 8'hB4);
    do_read();
    check("R4 ring clear", status_q, 8'hB0);
  endtask

  task automatic t_dsr_dcd();
    dsr_pin = 1'b0;
    dcd_pin = 1'b0;
    edges(3);
    check("R2 dsr dcd fall", status_q, 8'h1A);
    do_read();
    dsr_pin = 1'b1;
    dcd_pin = 1'b1;
    edges(3);
    check("R2 dsr dcd rise", status_q, 8'hBA);
    do_read();
    check("R4 clear3", status_q, 8'hB0);
  endtask

  task automatic t_race();
    dsr_pin = 1'b0;
    edges(3);
    check("R5 pre", status_q, 8'h92);
    cts_pin = 1'b0;
    edges(2);
    do_read();
    check("R5 coincident", status_q, 8'h81);
    do_read();
    check("R5 after", status_q, 8'h80);
    cts_pin = 1'b1;
    dsr_pin = 1'b1;
    edges(3);
    do_read();
    check("R5 restore", status_q, 8'hB0);
  endtask

  task automatic t_loop();
    ctl_bits = 5'b11000;
    edges(0);
    @(negedge clk);
    check("R7 enter", status_q, 8'h83);
    do_read();
    check("R7 clear", status_q, 8'h80);
    ctl_bits = 5'b10111;
    @(negedge clk);
    check("R7 map", status_q, 8'h7B);
    do_read();
    cts_pin = 1'b0;
    dcd_pin = 1'b0;
    edges(4);
    check("R7 pins ignored", status_q, 8'h70);
    ctl_bits = 5'b10011;
    @(negedge clk);
    check("R7 out1 fall", status_q, 8'h34);
    do_read();
    cts_pin = 1'b1;
    dcd_pin = 1'b1;
    edges(3);
    ctl_bits = 5'b01000;
    @(negedge clk);
    check("R7 leave", status_q, 8'hB8);
    do_read();
    check("R7 final", status_q, 8'hB0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cts();
    t_ring();
    t_dsr_dcd();
    t_race();
    t_loop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule